// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Override

This block is a five-pin general-purpose I/O port that sits on a simple byte-wide register bus. It holds a data latch and a direction setting for each pin. From these it drives a per-pin output enable and output value towards the pads, and it returns read data built from the latches or from the sampled pad inputs.

Two pins can be handed to a serial peripheral. Pin 0 then carries transmit data out, and pin 1 brings receive data in. Two other pins can be handed to the clock generator. Pin 4 becomes an external clock input and pin 3 a clock output. Peripheral ownership overrides the pin direction. The direction bit still decides what a read of the data register returns for a serial pin. Pins owned by the oscillator ignore writes to their data bits.

Writes take effect on the rising clock edge. Reads are combinational on the address.

Top module: `gpio5_port`

## Requirements
- R1: The data register is at offset 0x08 and the direction register at offset 0x0C. Each holds pins 4..0 in bits 4..0, and bits 7..5 read 0. A read at any other offset returns 0x00.
- R2: An active-low asynchronous reset clears every direction bit, so all five output enables are 0 after reset.
- R3: Reset leaves the data latches unchanged; their values before reset read back after reset.
- R4: For a general-purpose pin, a direction bit of 1 drives output enable 1 with the latch value on the output. A direction bit of 0 drives output enable 0.
- R5: Reading the data register returns, per bit, the latch when the direction bit is 1 and the sampled pin input when it is 0.
- R6: A write to the data register updates the latch even while the direction bit is 0. The value appears on the pin once the direction is set to 1.
- R7: With serial enable 1, pin 0 has output enable 1 and outputs the transmit data input, and pin 1 has output enable 0, whatever the direction bits are. The receive output always follows pin 1's input.
- R8: With serial enable 1, reads of bits 1..0 still select latch or pin input by the direction bit.
- R9: Pin 4 becomes a clock input (output enable 0, clock output port follows pin 4) only when both its select and enable are 1. Pin 3 becomes a clock output (output enable 1, value equals the clock input) only when both its select and enable are 1. Otherwise each pin is general-purpose.
- R10: A write to the data bit of an oscillator-owned pin leaves that latch unchanged. Other bits are still written. The read value of such a bit is undefined; it is returned as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| pin_in_i | input | 5 | Sampled pad inputs |
| pin_oe_o | output | 5 | Per-pin output enable |
| pin_out_o | output | 5 | Per-pin output value |
| ser_en_i | input | 1 | Serial peripheral owns pins 1..0 |
| ser_txd_i | input | 1 | Transmit data from the serial peripheral |
| ser_rxd_o | output | 1 | Receive data to the serial peripheral |
| osc_in_sel_i | input | 1 | Configuration select for pin 4 clock input |
| osc_in_en_i | input | 1 | Clock generator enable for pin 4 clock input |
| osc_out_sel_i | input | 1 | Configuration select for pin 3 clock output |
| osc_out_en_i | input | 1 | Clock generator enable for pin 3 clock output |
| osc_clk_i | input | 1 | Clock driven onto pin 3 |
| osc_ext_clk_o | output | 1 | External clock taken from pin 4 |

## Verification
A vector table sweeps direction, latch and pin-input patterns chosen so that no pin's latch and pad value agree everywhere. This shows whether a read returns the latch or the pad for each bit, and whether each enable follows its own direction bit. Serial tests drive opposing direction settings and transmit values, to show that ownership overrides the enables but not the read selection. Oscillator tests assert select and enable one at a time and then together, to separate the two-input condition. A write made under oscillator ownership is read back after ownership ends, to show that the latch was blocked.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
  localparam int unsigned NPIN        = 5;
  localparam int unsigned DW          = 8;
  localparam int unsigned AW          = 8;
  localparam int unsigned PIN_TXD     = 0;
  localparam int unsigned PIN_RXD     = 1;
  localparam int unsigned PIN_OSC_OUT = 3;
  localparam int unsigned PIN_OSC_IN  = 4;

  typedef struct packed {
    logic ser;
    logic osc_in;
    logic osc_out;
  } own_t;

  function automatic logic [NPIN-1:0] osc_mask(own_t own);
    logic [NPIN-1:0] m;
    m = '0;
    m[PIN_OSC_IN]  = own.osc_in;
    m[PIN_OSC_OUT] = own.osc_out;
    return m;
  endfunction
endpackage

// File: rtl/gpio5_regs.sv
module gpio5_regs
  import gpio5_pkg::*;
#(
  parameter logic [AW-1:0] DATA_OFFS = 8'h08,
  parameter logic [AW-1:0] DIR_OFFS  = 8'h0C
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  input  logic [NPIN-1:0] wr_block_i,
  output logic [NPIN-1:0] latch_o,
  output logic [NPIN-1:0] dir_o
);
  logic wr_data, wr_dir;
  assign wr_data = we_i && (addr_i == DATA_OFFS);
  assign wr_dir  = we_i && (addr_i == DIR_OFFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= '0;
    else if (wr_dir) dir_o <= wdata_i;
  end

  // data latches carry no reset
  for (genvar b = 0; b < NPIN; b++) begin : g_latch
    always_ff @(posedge clk_i) begin
      if (wr_data && !wr_block_i[b]) latch_o[b] <= wdata_i[b];
    end

    assert_osc_wr_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_data && wr_block_i[b]) |=> $stable(latch_o[b]));

    assert_latch_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_data && !wr_block_i[b]) |=> (latch_o[b] == $past(wdata_i[b])));
  end

  assert_dir_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> (dir_o == $past(wdata_i)));

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(dir_o));
endmodule

// File: rtl/gpio5_pin_mux.sv
module gpio5_pin_mux
  import gpio5_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] latch_i,
  input  own_t            own_i,
  input  logic            ser_txd_i,
  input  logic            osc_clk_i,
  output logic [NPIN-1:0] oe_o,
  output logic [NPIN-1:0] out_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (p == PIN_TXD) begin : g_txd
      always_comb begin
        oe_o[p]  = own_i.ser ? 1'b1 : dir_i[p];
        out_o[p] = own_i.ser ? ser_txd_i : latch_i[p];
      end
    end else if (p == PIN_RXD) begin : g_rxd
      always_comb begin
        oe_o[p]  = own_i.ser ? 1'b0 : dir_i[p];
        out_o[p] = latch_i[p];
      end
    end else if (p == PIN_OSC_OUT) begin : g_ckout
      always_comb begin
        oe_o[p]  = own_i.osc_out ? 1'b1 : dir_i[p];
        out_o[p] = own_i.osc_out ? osc_clk_i : latch_i[p];
      end
    end else if (p == PIN_OSC_IN) begin : g_ckin
      always_comb begin
        oe_o[p]  = own_i.osc_in ? 1'b0 : dir_i[p];
        out_o[p] = latch_i[p];
      end
    end else begin : g_gp
      always_comb begin
        oe_o[p]  = dir_i[p];
        out_o[p] = latch_i[p];
      end
    end
  end

  assert_rx_not_driven_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i.ser |-> !oe_o[PIN_RXD]);
  assert_ckin_not_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i.osc_in |-> !oe_o[PIN_OSC_IN]);
  assert_ckout_driven_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_i.osc_out |-> oe_o[PIN_OSC_OUT]);
endmodule

// File: rtl/gpio5_read_mux.sv
module gpio5_read_mux
  import gpio5_pkg::*;
#(
  parameter logic [AW-1:0] DATA_OFFS = 8'h08,
  parameter logic [AW-1:0] DIR_OFFS  = 8'h0C
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] dir_i,
  input  logic [NPIN-1:0] latch_i,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] osc_own_i,
  output logic [DW-1:0]   rdata_o
);
  logic [NPIN-1:0] data_view;

  for (genvar b = 0; b < NPIN; b++) begin : g_bit
    // undefined read for oscillator pins returned as 0
    assign data_view[b] = osc_own_i[b] ? 1'b0 : (dir_i[b] ? latch_i[b] : pin_i[b]);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == DATA_OFFS)     rdata_o[NPIN-1:0] = data_view;
    else if (addr_i == DIR_OFFS) rdata_o[NPIN-1:0] = dir_i;
  end

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NPIN] == '0);
  assert_unmapped_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != DATA_OFFS && addr_i != DIR_OFFS) |-> rdata_o == '0);
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
  import gpio5_pkg::*;
#(
  parameter logic [AW-1:0] DATA_OFFS = 8'h08,
  parameter logic [AW-1:0] DIR_OFFS  = 8'h0C
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NPIN-1:0] pin_in_i,
  output logic [NPIN-1:0] pin_oe_o,
  output logic [NPIN-1:0] pin_out_o,
  input  logic            ser_en_i,
  input  logic            ser_txd_i,
  output logic            ser_rxd_o,
  input  logic            osc_in_sel_i,
  input  logic            osc_in_en_i,
  input  logic            osc_out_sel_i,
  input  logic            osc_out_en_i,
  input  logic            osc_clk_i,
  output logic            osc_ext_clk_o
);
  own_t            own;
  logic [NPIN-1:0] osc_own, latch, dir;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:NPIN];

  assign own.ser     = ser_en_i;
  assign own.osc_in  = osc_in_sel_i && osc_in_en_i;
  assign own.osc_out = osc_out_sel_i && osc_out_en_i;
  assign osc_own     = osc_mask(own);

  assign ser_rxd_o     = pin_in_i[PIN_RXD];
  assign osc_ext_clk_o = pin_in_i[PIN_OSC_IN];

  gpio5_regs #(.DATA_OFFS(DATA_OFFS), .DIR_OFFS(DIR_OFFS)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i[NPIN-1:0]),
    .wr_block_i (osc_own),
    .latch_o    (latch),
    .dir_o      (dir)
  );

  gpio5_pin_mux u_pins (
    .clk_i, .rst_ni,
    .dir_i     (dir),
    .latch_i   (latch),
    .own_i     (own),
    .ser_txd_i (ser_txd_i),
    .osc_clk_i (osc_clk_i),
    .oe_o      (pin_oe_o),
    .out_o     (pin_out_o)
  );

  gpio5_read_mux #(.DATA_OFFS(DATA_OFFS), .DIR_OFFS(DIR_OFFS)) u_rd (
    .clk_i, .rst_ni,
    .addr_i    (bus_addr_i),
    .dir_i     (dir),
    .latch_i   (latch),
    .pin_i     (pin_in_i),
    .osc_own_i (osc_own),
    .rdata_o   (bus_rdata_o)
  );

  assert_rxd_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_rxd_o == pin_in_i[PIN_RXD]);
endmodule

// File: tb/sim_gpio5_port.sv
module sim_gpio5_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h08;
  localparam logic [7:0] A_DIR  = 8'h0C;
  localparam int NVEC = 6;
  // {dir, latch, pin_in}
  localparam logic [14:0] VEC [NVEC] = '{
    {5'h1F, 5'h15, 5'h0A},
    {5'h00, 5'h15, 5'h0A},
    {5'h0F, 5'h03, 5'h1C},
    {5'h10, 5'h1E, 5'h01},
    {5'h15, 5'h0C, 5'h13},
    {5'h0A, 5'h1F, 5'h00}
  };

  logic clk = 0, rst_ni = 0, we = 0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [4:0] pin_in = 5'h00, oe, pout;
  logic ser_en = 0, txd = 0, rxd;
  logic ins = 0, ine = 0, outs = 0, oute = 0, oclk = 0, eclk;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio5_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_in_i(pin_in),
    .pin_oe_o(oe), .pin_out_o(pout), .ser_en_i(ser_en), .ser_txd_i(txd),
    .ser_rxd_o(rxd), .osc_in_sel_i(ins), .osc_in_en_i(ine),
    .osc_out_sel_i(outs), .osc_out_en_i(oute), .osc_clk_i(oclk),
    .osc_ext_clk_o(eclk)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [4:0] vd, vl, vp;
    repeat (3) @(negedge clk);
    // R2: direction cleared in reset
    chk("R2 oe in reset", {3'b0, oe}, 8'h00);
    rst_ni = 1;
    rd(A_DIR, r); chk("R2 dir after reset", r, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      {vd, vl, vp} = VEC[i];
      wr(A_DIR, {3'b0, vd});
      wr(A_DATA, {3'b0, vl});
      pin_in = vp;
      rd(A_DATA, r);
      chk("R5 read mux", r, {3'b0, (vd & vl) | (~vd & vp)});
      chk("R4 oe", {3'b0, oe}, {3'b0, vd});
      chk("R4 out", {3'b0, pout & vd}, {3'b0, vl & vd});
    end

    // R1: widths and offsets
    wr(A_DIR, 8'hFF);
    rd(A_DIR, r); chk("R1 dir upper bits", r, 8'h1F);
    wr(A_DATA, 8'hEA);
    rd(A_DATA, r); chk("R1 data upper bits", r, 8'h0A);
    rd(8'h10, r); chk("R1 unmapped", r, 8'h00);
    rd(8'h09, r); chk("R1 unmapped near", r, 8'h00);

    // R3: latch survives reset
    wr(A_DATA, 8'h15);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    #1 chk("R2 oe after reset", {3'b0, oe}, 8'h00);
    pin_in = 5'h00;
    wr(A_DIR, 8'h1F);
    rd(A_DATA, r); chk("R3 latch kept", r, 8'h15);

    // R6: write while input
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h0A);
    pin_in = 5'h11;
    rd(A_DATA, r); chk("R6 read pins while input", r, 8'h11);
    wr(A_DIR, 8'h1F);
    #1 chk("R6 out after dir", {3'b0, pout}, 8'h0A);

    // R7/R8: serial ownership
    wr(A_DIR, 8'h02);
    wr(A_DATA, 8'h01);
    ser_en = 1; txd = 0; pin_in = 5'h02;
    #1;
    chk("R7 tx oe", {7'b0, oe[0]}, 8'h01);
    chk("R7 tx value", {7'b0, pout[0]}, 8'h00);
    chk("R7 rx oe", {7'b0, oe[1]}, 8'h00);
    chk("R7 rxd", {7'b0, rxd}, 8'h01);
    txd = 1; pin_in = 5'h00;
    #1 chk("R7 tx follows", {7'b0, pout[0]}, 8'h01);
    chk("R7 rxd low", {7'b0, rxd}, 8'h00);
    rd(A_DATA, r); chk("R8 read dir 10", {6'b0, r[1:0]}, 8'h00);
    pin_in = 5'h03;
    wr(A_DIR, 8'h01);
    rd(A_DATA, r); chk("R8 read dir 01", {6'b0, r[1:0]}, 8'h03);
    ser_en = 0;
    #1 chk("R7 released", {6'b0, oe[1:0]}, 8'h01);

    // R9: oscillator ownership
    wr(A_DIR, 8'h18);
    wr(A_DATA, 8'h00);
    ins = 1; ine = 0; outs = 0; oute = 1; oclk = 1;
    #1 chk("R9 partial gpio", {6'b0, oe[4:3]}, 8'h03);
    chk("R9 partial out", {7'b0, pout[3]}, 8'h00);
    ine = 1; outs = 1; pin_in = 5'h10;
    #1 chk("R9 owned oe", {6'b0, oe[4:3]}, 8'h01);
    chk("R9 clk out", {7'b0, pout[3]}, 8'h01);
    chk("R9 ext clk", {7'b0, eclk}, 8'h01);
    oclk = 0; pin_in = 5'h00;
    #1 chk("R9 clk out low", {7'b0, pout[3]}, 8'h00);
    chk("R9 ext clk low", {7'b0, eclk}, 8'h00);

    // R10: writes to owned bits blocked
    wr(A_DIR, 8'h1F);
    wr(A_DATA, 8'h1F);
    ins = 0; ine = 0; outs = 0; oute = 0;
    rd(A_DATA, r); chk("R10 write blocked", r, 8'h07);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule